// File: doc/BRIEF.md
# 16-bit ALU with flag generation

This block is the arithmetic and logic stage of a small 16-bit processor datapath. Each cycle it takes a 16-bit register operand, a 16-bit immediate operand, an operation select and an execute strobe. It returns a 16-bit result with a write-enable for the destination register. It also returns four freshly computed condition flags with their own update-enable. The datapath is combinational. The only state is an 8-bit flag register, which captures the new flags on the clock edge of every flag-updating operation and holds them between instructions for later conditional branches.

Add, subtract and compare always refresh all four flags. Compare does the same subtraction as subtract but never asserts the write-enable, so the destination register is left alone. The bitwise operations (AND, OR, XOR with the immediate, and NOT of the register operand) write their result and leave the flag register untouched. The carry flag means carry-out after an add and borrow after a subtract or compare.

Operation select encoding (`op_i`): 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 NOT, 7 reserved.

Top module: `alu16_flags`

## Requirements
- R1: For op 0 with exec_i high, result_o = (reg_a_i + imm_i) mod 2^16 and wr_en_o is 1. The carry flag is the unsigned carry-out, and overflow is set when the signed sum lies outside -32768..32767 (0x7FFF + 0x0001 gives 0x8000 with flags 0x0C).
- R2: For op 1 with exec_i high, result_o = (reg_a_i - imm_i) mod 2^16 and wr_en_o is 1. The carry flag is set when imm_i > reg_a_i as unsigned values, and overflow is set when the signed difference lies outside -32768..32767 (0x0001 - 0x0001 gives flags 0x01).
- R3: For op 2 with exec_i high, the flags are computed exactly as for op 1, flag_upd_o is 1, and wr_en_o is 0 (5 compared with 10 gives flags 0x06; 0x00AA compared with 0x00AA gives 0x01).
- R4: For ops 0, 1 and 2, zero is set exactly when the 16-bit result is 0x0000, and sign equals bit 15 of the result.
- R5: The flag vector flag_new_o and the low nibble of flags_q_o use bit 0 = zero, bit 1 = carry, bit 2 = sign, bit 3 = overflow. Bits 7..4 of flags_q_o always read 0.
- R6: Ops 3, 4 and 5 with exec_i high set result_o to the bitwise AND, OR or XOR of reg_a_i and imm_i, with wr_en_o 1 (0x0F0F AND 0x00FF = 0x000F; 0xAAAA XOR 0xFFFF = 0x5555).
- R7: Op 6 with exec_i high sets result_o to the complement of reg_a_i whatever imm_i holds, with wr_en_o 1 (0x33FF becomes 0xCC00).
- R8: Ops 3 to 6 drive flag_upd_o to 0, and flags_q_o is unchanged after their clock edge.
- R9: While rst is high at a clock edge, flags_q_o becomes 0x00, even if a flag-updating operation is presented in the same cycle.
- R10: When exec_i is 0, or op_i is 7, wr_en_o and flag_upd_o are 0 and flags_q_o keeps its value.
- R11: When flag_upd_o is 1 at a clock edge, flags_q_o[3:0] takes the value of flag_new_o after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| exec_i | input | 1 | Operation is valid this cycle |
| op_i | input | 3 | Operation select (encoding above) |
| reg_a_i | input | 16 | Register operand |
| imm_i | input | 16 | Immediate operand |
| result_o | output | 16 | Operation result |
| wr_en_o | output | 1 | Write result back to the destination register |
| flag_new_o | output | 4 | Newly computed flags {overflow, sign, carry, zero} |
| flag_upd_o | output | 1 | Flags are to be captured this cycle |
| flags_q_o | output | 8 | Stored flag register |

## Verification
Several properties are checked on every cycle. Compare never asserts the write-enable. Zero and sign agree with the result whenever flags update. The register's upper nibble stays clear. A capture loads flag_new_o, and a cycle with no update holds the register. Reset clears it. The arithmetic itself cannot be seen by a property: carry and borrow polarity, signed overflow at the range edges, the values of the bitwise operations and NOT ignoring the immediate are shown only by the bench. The bench compares each operation against its own model, using directed corners such as 0x7FFF + 1, 5 compared with 10 and equal compares, plus seeded random operands.

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int W = 16,
  parameter int FW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] reg_a_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flag_new_o,
  output logic         flag_upd_o,
  output logic [FW-1:0] flags_q_o
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_CMP = 3'd2,
                         OP_AND = 3'd3, OP_OR  = 3'd4, OP_XOR = 3'd5,
                         OP_NOT = 3'd6;
  localparam int MSB = W - 1;

  logic [W:0]   sum_x, dif_x;
  logic         is_arith, is_write, carry, ovf;
  logic [W-1:0] res;

  assign sum_x = {1'b0, reg_a_i} + {1'b0, imm_i};
  assign dif_x = {1'b0, reg_a_i} - {1'b0, imm_i};

  always_comb begin
    res      = '0;
    carry    = 1'b0;
    ovf      = 1'b0;
    is_arith = 1'b0;
    is_write = 1'b1;
    case (op_i)
      OP_ADD: begin
        res      = sum_x[W-1:0];
        carry    = sum_x[W];
        ovf      = (reg_a_i[MSB] == imm_i[MSB]) && (res[MSB] != reg_a_i[MSB]);
        is_arith = 1'b1;
      end
      OP_SUB, OP_CMP: begin
        res      = dif_x[W-1:0];
        carry    = dif_x[W];
        ovf      = (reg_a_i[MSB] != imm_i[MSB]) && (res[MSB] != reg_a_i[MSB]);
        is_arith = 1'b1;
        is_write = (op_i == OP_SUB);
      end
      OP_AND:  res = reg_a_i & imm_i;
      OP_OR:   res = reg_a_i | imm_i;
      OP_XOR:  res = reg_a_i ^ imm_i;
      OP_NOT:  res = ~reg_a_i;
      default: is_write = 1'b0;
    endcase
  end

  assign result_o   = res;
  assign wr_en_o    = exec_i && is_write;
  assign flag_upd_o = exec_i && is_arith;
  assign flag_new_o = {ovf, res[MSB], carry, (res == '0)};

  always_ff @(posedge clk) begin
    if (rst)             flags_q_o <= '0;
    else if (flag_upd_o) flags_q_o <= {{(FW-4){1'b0}}, flag_new_o};
  end
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk #(
  parameter int W = 16,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          exec_i,
  input logic [2:0]    op_i,
  input logic [W-1:0]  result_o,
  input logic          wr_en_o,
  input logic [3:0]    flag_new_o,
  input logic          flag_upd_o,
  input logic [FW-1:0] flags_q_o
);
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (exec_i && op_i == 3'd2) |-> (flag_upd_o && !wr_en_o)); // R3
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (rst) flag_upd_o |-> (flag_new_o[0] == (result_o == '0) && flag_new_o[2] == result_o[W-1])); // R4
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst) flags_q_o[FW-1:4] == '0); // R5
  AST_LOGIC_NO_FLAGS: assert property (@(posedge clk) disable iff (rst) (op_i >= 3'd3) |-> !flag_upd_o); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !flag_upd_o |=> $stable(flags_q_o)); // R10
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst) flag_upd_o |=> flags_q_o[3:0] == $past(flag_new_o)); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> flags_q_o == '0); // R9
endmodule

bind alu16_flags alu16_flags_chk #(.W(W), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i), .result_o(result_o),
  .wr_en_o(wr_en_o), .flag_new_o(flag_new_o), .flag_upd_o(flag_upd_o),
  .flags_q_o(flags_q_o)
);

// File: tb/tb_alu16_flags.sv
module tb_alu16_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] reg_a_i = '0, imm_i = '0;
  logic [15:0] result_o;
  logic        wr_en_o, flag_upd_o;
  logic [3:0]  flag_new_o;
  logic [7:0]  flags_q_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model_q = 8'h00;

  always #10 clk = ~clk;

  alu16_flags dut (
    .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i), .reg_a_i(reg_a_i),
    .imm_i(imm_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flag_new_o(flag_new_o), .flag_upd_o(flag_upd_o), .flags_q_o(flags_q_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd6: return "R7";
      3'd7: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic model(input logic ex, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       output logic [15:0] r, output logic wr, output logic [3:0] f, output logic upd);
    int sa, sb, sv;
    logic c;
    sa = $signed(a); sb = $signed(b);
    r = '0; c = 1'b0; sv = 0; f = '0;
    case (op)
      3'd0: begin r = a + b; c = (int'(a) + int'(b)) > 65535; sv = sa + sb; end
      3'd1, 3'd2: begin r = a - b; c = b > a; sv = sa - sb; end
      3'd3: r = a & b;
      3'd4: r = a | b;
      3'd5: r = a ^ b;
      3'd6: r = ~a;
      default: r = '0;
    endcase
    upd = ex && (op <= 3'd2);
    wr  = ex && (op <= 3'd1 || (op >= 3'd3 && op <= 3'd6));
    if (op <= 3'd2) f = {(sv > 32767 || sv < -32768), r[15], c, (r == 16'h0000)};
  endtask

  // Drive at negedge, check combinational outputs, then the register after the edge.
  task automatic run_op(input logic ex, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] er; logic ew, eu; logic [3:0] ef;
    @(negedge clk);
    exec_i = ex; op_i = op; reg_a_i = a; imm_i = b;
    model(ex, op, a, b, er, ew, ef, eu);
    #2;
    check(ex ? req_of(op) : "R10", "wr_en", int'(wr_en_o), int'(ew));
    check((op >= 3'd3) ? "R8" : (ex ? req_of(op) : "R10"), "flag_upd", int'(flag_upd_o), int'(eu));
    if (ew) check(req_of(op), "result", int'(result_o), int'(er));
    if (op <= 3'd2) check("R4", "flag_new", int'(flag_new_o), int'(ef));
    if (eu) model_q = {4'h0, ef};
    @(negedge clk);
    check(eu ? "R11" : "R8", "flags_q", int'(flags_q_o), int'(model_q));
    exec_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #2 check("R9", "flags_q after reset", int'(flags_q_o), 8'h00);

    run_op(1, 3'd0, 16'h7FFF, 16'h0001);
    check("R1", "0x7FFF+1 flags", int'(flags_q_o), 8'h0C);
    run_op(1, 3'd0, 16'hFFFF, 16'h0001);
    check("R1", "0xFFFF+1 flags", int'(flags_q_o), 8'h03);
    run_op(1, 3'd1, 16'h0001, 16'h0001);
    check("R2", "1-1 flags", int'(flags_q_o), 8'h01);
    run_op(1, 3'd1, 16'h8000, 16'h0001);
    check("R2", "0x8000-1 flags", int'(flags_q_o), 8'h08);
    run_op(1, 3'd2, 16'h0005, 16'h000A);
    check("R3", "5 cmp 10 flags", int'(flags_q_o), 8'h06);
    run_op(1, 3'd2, 16'h00AA, 16'h00AA);
    check("R3", "equal cmp flags", int'(flags_q_o), 8'h01);
    run_op(1, 3'd3, 16'h0F0F, 16'h00FF);
    check("R8", "flags after AND", int'(flags_q_o), 8'h01);
    run_op(1, 3'd5, 16'hAAAA, 16'hFFFF);
    run_op(1, 3'd4, 16'h0001, 16'h0004);
    run_op(1, 3'd6, 16'h33FF, 16'h1234);
    run_op(1, 3'd6, 16'h0F0F, 16'hFFFF);
    run_op(0, 3'd0, 16'h7FFF, 16'h0001);
    run_op(1, 3'd7, 16'h0000, 16'h0000);
    check("R10", "flags after idle/reserved", int'(flags_q_o), 8'h01);

    for (int i = 0; i < 400; i++)
      run_op(($urandom % 8) != 0, 3'($urandom % 8), 16'($urandom), 16'($urandom));

    run_op(1, 3'd1, 16'h0000, 16'h0001);
    @(negedge clk);
    rst = 1'b1; exec_i = 1'b1; op_i = 3'd0; reg_a_i = 16'h7FFF; imm_i = 16'h0001;
    @(negedge clk);
    check("R9", "flags_q reset over update", int'(flags_q_o), 8'h00);
    rst = 1'b0; exec_i = 1'b0;
    model_q = 8'h00;
    finish_run();
  end
endmodule